// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer with Direction Counters

This block sits in the instruction fetch stage and is looked up with the fetch address in the same cycle that address is presented. It is a small direct-mapped cache of branches that have already been seen. A hit means the instruction at that address is a known branch. Each entry stores the branch's target address and a 2-bit saturating counter. The counter decides whether the next fetch goes to the stored target or to the sequential address. The block therefore produces the next fetch PC before decode, and fetch from the target can begin on the following cycle.

A second port takes resolved branches from later in the pipeline: the branch address, its target and whether it was taken. Updates are combined with a lookup of the resolving address. That lookup raises one flag for a taken branch that had no entry (misfetch) and another for a hit whose direction prediction was wrong (mispredict). It then allocates or trains the entry on the next clock edge.

Top module: `fetchTargetBuffer`

## Requirements
- R1: After reset, including a reset applied in the middle of operation, every lookup misses: `fetchHit`=0, `fetchTaken`=0 and `nextPc`=`fetchPc`+4.
- R2: A lookup that misses gives `fetchHit`=0, `fetchTaken`=0 and `nextPc`=`fetchPc`+4 in the same cycle.
- R3: A taken resolve whose address misses allocates an entry. From the next cycle, a lookup of that address hits, predicts taken (counter value 2, weakly taken) and gives `nextPc` equal to the resolved target.
- R4: A not-taken resolve whose address misses changes nothing. A later lookup of that address still misses.
- R5: On a hit, `fetchTaken` equals bit 1 of the entry's counter. `nextPc` is the stored target when that bit is 1 and `fetchPc`+4 when it is 0, with `fetchHit`=1 in both cases.
- R6: A resolve that hits moves the counter one step toward the outcome: +1 when taken and -1 when not taken. The counter saturates at 0 and 3.
- R7: A resolve that hits overwrites the stored target with `resTarget`.
- R8: `misfetch` is 1, in the cycle of the resolve, exactly when `resValid`=1, `resTaken`=1 and `resPc` misses.
- R9: `mispredict` is 1, in the cycle of the resolve, exactly when `resValid`=1, `resPc` hits, and bit 1 of the entry's counter differs from `resTaken`.
- R10: The entry index is `PC[IDX_W+1:2]`, and the bits above it form the tag. An address with the same index and a different tag misses. Allocating that address replaces the previous occupant, which then misses.
- R11: A lookup in the same cycle as an update sees the state from before the update. The update becomes visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, clears every valid bit |
| fetchPc | input | PC_W | Address being fetched this cycle |
| nextPc | output | PC_W | Predicted next fetch address |
| fetchHit | output | 1 | The fetch address is a known branch |
| fetchTaken | output | 1 | The known branch is predicted taken |
| resValid | input | 1 | A resolved branch is presented this cycle |
| resPc | input | PC_W | Address of the resolved branch |
| resTarget | input | PC_W | Target address of the resolved branch |
| resTaken | input | 1 | Actual outcome of the resolved branch |
| misfetch | output | 1 | Taken branch had no entry |
| mispredict | output | 1 | Entry hit, but the predicted direction was wrong |

## Verification
The assertions assume that `resPc`, `resTarget` and `resTaken` are driven to known values whenever `resValid` is high. They also assume that at most one resolve arrives per cycle, because the update port has a single write. The bench drives every input from a task half a clock away from the active edge. It holds `resValid` low whenever it only wants a lookup, and it keeps all addresses word-aligned. Sweeps cover every index with its own tag, an aliasing tag at the same index, a full walk of the counter through both saturation points, and a reset in mid-run.

// File: rtl/ftbPkg.sv
package ftbPkg;
  // strobes sent from control to datapath for the resolve port
  typedef struct packed {
    logic       write;    // write the entry selected by the resolve address
    logic [1:0] ctrNext;  // counter value to store
  } ftbStrobe_t;
endpackage

// File: rtl/ftbDatapath.sv
module ftbDatapath
  import ftbPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic             resValid,
  input  logic             resTaken,
  input  logic [PC_W-1:0]  resPc,
  input  logic [PC_W-1:0]  resTarget,
  input  ftbStrobe_t       strobe,
  output logic             fetchHit,
  output logic [1:0]       fetchCtr,
  output logic [PC_W-1:0]  fetchTarget,
  output logic             resHit,
  output logic [1:0]       resCtr
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_LO  = IDX_W + 2;
  localparam int TAG_W   = PC_W - TAG_LO;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ    [ENTRIES];
  logic [PC_W-1:0]    targetQ [ENTRIES];
  logic [1:0]         ctrQ    [ENTRIES];

  logic [IDX_W-1:0] fetchIdx, resIdx;
  logic [TAG_W-1:0] fetchTag, resTag;

  assign fetchIdx = fetchPc[IDX_W+1:2];
  assign fetchTag = fetchPc[PC_W-1:TAG_LO];
  assign resIdx   = resPc[IDX_W+1:2];
  assign resTag   = resPc[PC_W-1:TAG_LO];

  // lookup for fetch, reads state before any same-cycle write
  assign fetchHit    = validQ[fetchIdx] && (tagQ[fetchIdx] == fetchTag);
  assign fetchCtr    = ctrQ[fetchIdx];
  assign fetchTarget = targetQ[fetchIdx];

  // lookup for the resolve port
  assign resHit = validQ[resIdx] && (tagQ[resIdx] == resTag);
  assign resCtr = ctrQ[resIdx];

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
      logic wrSel;
      assign wrSel = strobe.write && (resIdx == IDX_W'(e));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      validQ[e] <= 1'b0;
        else if (wrSel) validQ[e] <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (wrSel) begin
          tagQ[e]    <= resTag;
          targetQ[e] <= resTarget;
          ctrQ[e]    <= strobe.ctrNext;
        end
      end
    end
  endgenerate

  // a taken resolve always leaves its index valid
  p_alloc_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resTaken) |=> validQ[$past(resIdx)]);

  // a not-taken miss never writes
  p_no_alloc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resTaken && !resHit) |-> !strobe.write);

  // counter moves toward the outcome by at most one
  p_ctr_up_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && resHit && resTaken) |->
      (strobe.ctrNext >= resCtr) && (3'(strobe.ctrNext) <= 3'(resCtr) + 3'd1));
  p_ctr_down_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && resHit && !resTaken) |->
      (strobe.ctrNext <= resCtr) && (3'(resCtr) <= 3'(strobe.ctrNext) + 3'd1));

  // hit update keeps the entry owned by the same address
  p_hit_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit) |=> validQ[$past(resIdx)]);
endmodule

// File: rtl/ftbControl.sv
module ftbControl
  import ftbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        resValid,
  input  logic        resTaken,
  input  logic        resHit,
  input  logic [1:0]  resCtr,
  output ftbStrobe_t  strobe,
  output logic        misfetch,
  output logic        mispredict
);
  localparam logic [1:0] CTR_MAX  = 2'd3;
  localparam logic [1:0] CTR_MIN  = 2'd0;
  localparam logic [1:0] CTR_WEAK = 2'd2;

  logic [1:0] stepped;

  always_comb begin
    if (resTaken) stepped = (resCtr == CTR_MAX) ? CTR_MAX : resCtr + 2'd1;
    else          stepped = (resCtr == CTR_MIN) ? CTR_MIN : resCtr - 2'd1;
  end

  always_comb begin
    strobe = '0;
    if (resValid) begin
      if (resHit) begin
        strobe.write   = 1'b1;
        strobe.ctrNext = stepped;
      end else if (resTaken) begin
        strobe.write   = 1'b1;
        strobe.ctrNext = CTR_WEAK;
      end
    end
  end

  assign misfetch   = resValid && resTaken && !resHit;
  assign mispredict = resValid && resHit && (resCtr[1] != resTaken);

  // the two penalty flags never coincide
  p_flags_apart_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(misfetch && mispredict));

  // every misfetch results in a write
  p_misfetch_alloc_r8: assert property (@(posedge clk) disable iff (!rstN)
    misfetch |-> strobe.write && (strobe.ctrNext == CTR_WEAK));
endmodule

// File: rtl/fetchTargetBuffer.sv
module fetchTargetBuffer
  import ftbPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  output logic [PC_W-1:0]  nextPc,
  output logic             fetchHit,
  output logic             fetchTaken,
  input  logic             resValid,
  input  logic [PC_W-1:0]  resPc,
  input  logic [PC_W-1:0]  resTarget,
  input  logic             resTaken,
  output logic             misfetch,
  output logic             mispredict
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  ftbStrobe_t      strobe;
  logic [1:0]      fetchCtr, resCtr;
  logic [PC_W-1:0] fetchTarget;
  logic            resHit;

  ftbDatapath #(.PC_W(PC_W), .IDX_W(IDX_W)) uDatapath (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc),
    .resValid(resValid), .resTaken(resTaken),
    .resPc(resPc), .resTarget(resTarget), .strobe(strobe),
    .fetchHit(fetchHit), .fetchCtr(fetchCtr), .fetchTarget(fetchTarget),
    .resHit(resHit), .resCtr(resCtr)
  );

  ftbControl uControl (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resTaken(resTaken),
    .resHit(resHit), .resCtr(resCtr), .strobe(strobe),
    .misfetch(misfetch), .mispredict(mispredict)
  );

  assign fetchTaken = fetchHit && fetchCtr[1];
  assign nextPc     = fetchTaken ? fetchTarget : fetchPc + STEP;

  p_seq_on_miss_r2: assert property (@(posedge clk) disable iff (!rstN)
    !fetchHit |-> (nextPc == fetchPc + STEP) && !fetchTaken);

  p_taken_needs_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    fetchTaken |-> fetchHit);
endmodule

// File: tb/fetchTargetBuffer_test.sv
`timescale 1ns/1ps
module fetchTargetBuffer_test;
  localparam int PC_W = 32;
  localparam int IDX_W = 3;
  localparam int N = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] fetchPc = '0, resPc = '0, resTarget = '0;
  logic resValid = 1'b0, resTaken = 1'b0;
  logic [PC_W-1:0] nextPc;
  logic fetchHit, fetchTaken, misfetch, mispredict;

  int errors = 0;
  int checks = 0;

  // requirement-level model of the table
  logic        mV [N];
  logic [26:0] mT [N];
  logic [31:0] mG [N];
  logic [1:0]  mC [N];

  always #2.5 clk = ~clk;

  fetchTargetBuffer #(.PC_W(PC_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .nextPc(nextPc),
    .fetchHit(fetchHit), .fetchTaken(fetchTaken), .resValid(resValid),
    .resPc(resPc), .resTarget(resTarget), .resTaken(resTaken),
    .misfetch(misfetch), .mispredict(mispredict)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < N; i++) mV[i] = 1'b0;
  endtask

  // one cycle: optional lookup check plus optional resolve
  task automatic cycle(input logic [31:0] fpc, input logic rv,
                       input logic [31:0] rpc, input logic [31:0] rtg,
                       input logic rt, input string lkTag, input string rsTag);
    logic [2:0] fi, ri;
    logic eh, et, rh, emf, emp;
    logic [31:0] enp;
    @(negedge clk);
    fetchPc = fpc; resValid = rv; resPc = rpc; resTarget = rtg; resTaken = rt;
    #1;
    fi  = fpc[4:2];
    eh  = mV[fi] && (mT[fi] == fpc[31:5]);
    et  = eh && mC[fi][1];
    enp = et ? mG[fi] : fpc + 32'd4;
    check(lkTag, "fetchHit", 32'(fetchHit), 32'(eh));
    check(lkTag, "fetchTaken", 32'(fetchTaken), 32'(et));
    check(lkTag, "nextPc", nextPc, enp);
    ri  = rpc[4:2];
    rh  = mV[ri] && (mT[ri] == rpc[31:5]);
    emf = rv && rt && !rh;
    emp = rv && rh && (mC[ri][1] != rt);
    check(rsTag, "misfetch", 32'(misfetch), 32'(emf));
    check(rsTag, "mispredict", 32'(mispredict), 32'(emp));
    if (rv) begin
      if (rh) begin
        mG[ri] = rtg;
        if (rt) mC[ri] = (mC[ri] == 2'd3) ? 2'd3 : mC[ri] + 2'd1;
        else    mC[ri] = (mC[ri] == 2'd0) ? 2'd0 : mC[ri] - 2'd1;
      end else if (rt) begin
        mV[ri] = 1'b1; mT[ri] = rpc[31:5]; mG[ri] = rtg; mC[ri] = 2'd2;
      end
    end
  endtask

  task automatic look(input logic [31:0] fpc, input string tag);
    cycle(fpc, 1'b0, 32'h0, 32'h0, 1'b0, tag, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic pattern [8];
    pattern = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    clearModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: empty table after reset
    for (int i = 0; i < N; i++) look({27'(i + 100), 3'(i), 2'b00}, "R1");

    for (int i = 0; i < N; i++) begin
      logic [31:0] pcA, pcC, tgA, tgB, tgC;
      pcA = {27'(i * 3 + 5), 3'(i), 2'b00};
      pcC = pcA ^ 32'h8000_0000;
      tgA = 32'h1000_0000 + 32'(i * 64);
      tgB = 32'h2000_0000 + 32'(i * 128);
      tgC = 32'h3000_0000 + 32'(i * 16);
      look(pcA, "R2");
      cycle(pcA, 1'b1, pcA, tgA, 1'b0, "R2", "R4");   // not-taken miss
      look(pcA, "R4");
      cycle(pcA, 1'b1, pcA, tgA, 1'b1, "R11", "R8");  // allocate
      look(pcA, "R3");
      for (int k = 0; k < 8; k++)
        cycle(pcA, 1'b1, pcA, tgA, pattern[k], "R5 R6 R11", "R9");
      cycle(pcA, 1'b1, pcA, tgB, 1'b1, "R11", "R7");
      look(pcA, "R7");
      look(pcC, "R10");
      cycle(pcC, 1'b1, pcC, tgC, 1'b1, "R10", "R8");
      look(pcA, "R10");
      look(pcC, "R10");
    end

    // R1: reset in the middle clears every entry
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    clearModel();
    for (int i = 0; i < N; i++) begin
      look({27'(i * 3 + 5), 3'(i), 2'b00}, "R1");
      look({27'(i * 3 + 5) ^ 27'h400_0000, 3'(i), 2'b00}, "R1");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule